// File: doc/BRIEF.md
# Hit Time Tag Encoder

This block turns sampled hit edges into time words. Each incoming hit carries three codes that were already digitised. The first is a coarse count of the fast clock within one reference period. The second is the index of the delay-line tap that caught the edge. The third is a sub-tap code from the interpolator. The block adds a count of 40 MHz reference periods that it keeps itself. From these four values it builds one linear time tag.

A run-time setting chooses which words come out. The choices are leading edges, trailing edges, both edges tagged by kind, or time-over-threshold. In time-over-threshold mode each channel remembers its last leading tag, and the following trailing edge emits the difference between the two. A second setting picks fine (sub-tap) or coarse (tap) resolution. A programmable offset is added to every edge tag. Results leave through a single registered valid/ready port.

Top module: `hit_timestamp_encoder`

## Requirements
- R1: After reset, out_valid is 0 and hit_ready is 1. The reference count starts at 0, so a hit before any ref_tick carries 0 in its reference field.
- R2: The raw tag is {reference count, hit_coarse, hit_tap, hit_sub}, most significant first. The sub-tap code sits in bits [1:0], the tap in bits [6:2] and the coarse count in bits [12:7]. The reference count sits above bit 12. The reference count rises by one on each cycle with ref_tick high, and the tag uses its value from before that increment.
- R3: With cfg_fine = 0, bits [1:0] of every output tag are 0, whatever the sub-tap code and the offset are.
- R4: Every edge word carries (raw tag + cfg_offset) modulo 2^TAG_W.
- R5: With cfg_mode = 0, only leading hits (hit_lead = 1) produce words, with kind 2'b01. Trailing hits produce nothing.
- R6: With cfg_mode = 1, only trailing hits produce words, with kind 2'b10. Leading hits produce nothing.
- R7: With cfg_mode = 2, every hit produces a word: kind 2'b01 for leading and 2'b10 for trailing.
- R8: With cfg_mode = 3, a leading hit produces no word and is stored for its channel. The next trailing hit on that channel emits kind 2'b11 with tag = (trailing tag − stored leading tag) modulo 2^TAG_W, with no offset applied.
- R9: With cfg_mode = 3, a trailing hit on a channel with no stored leading edge emits kind 2'b11 with the error bit set, and its tag is the offset trailing edge tag.
- R10: Channels pair their edges independently. A leading edge on one channel never pairs with a trailing edge on another.
- R11: The output word is {channel, kind[1:0], error, tag}. While out_valid is 1 and out_ready is 0, the word and out_valid hold. hit_ready is 1 exactly when out_valid is 0 or out_ready is 1.
- R12: The reference count wraps from its maximum value to 0. A time-over-threshold pair spanning the wrap still yields the correct modular difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One pulse per 40 MHz reference period |
| cfg_mode | input | 2 | 0 leading, 1 trailing, 2 both, 3 time-over-threshold |
| cfg_fine | input | 1 | 1 keeps sub-tap resolution, 0 drops it |
| cfg_offset | input | TAG_W | Offset added to edge tags |
| hit_valid | input | 1 | Hit snapshot present |
| hit_ready | output | 1 | Hit accepted this cycle when high with hit_valid |
| hit_chan | input | CH_W | Channel of the hit |
| hit_lead | input | 1 | 1 leading edge, 0 trailing edge |
| hit_coarse | input | CRS_W | Fast-clock count within the reference period |
| hit_tap | input | TAP_W | Delay-line tap index |
| hit_sub | input | SUB_W | Sub-tap interpolation code |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | CH_W+3+TAG_W | {channel, kind, error, tag} |

## Verification
The bench builds the block with four channels and a 4-bit reference count, which gives a 17-bit tag. At that size the whole tag range wraps after sixteen reference ticks. This makes it practical to test offsets that overflow the tag, and time-over-threshold pairs that straddle the wrap. Using four channels lets interleaved pairs on different channels show that one channel's stored edge never leaks into another's.

// File: rtl/hte_pkg.sv
package hte_pkg;
  typedef enum logic [1:0] {
    MODE_LEAD  = 2'd0,
    MODE_TRAIL = 2'd1,
    MODE_BOTH  = 2'd2,
    MODE_TOT   = 2'd3
  } mode_e;

  localparam logic [1:0] KIND_LEAD  = 2'b01;
  localparam logic [1:0] KIND_TRAIL = 2'b10;
  localparam logic [1:0] KIND_TOT   = 2'b11;
endpackage

// File: rtl/hte_refcnt.sv
module hte_refcnt #(
  parameter int REF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [REF_W-1:0] cnt
);
  logic [REF_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (tick) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  a_r2_refcnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/hte_tag.sv
module hte_tag #(
  parameter int REF_W = 12,
  parameter int CRS_W = 6,
  parameter int TAP_W = 5,
  parameter int SUB_W = 2,
  parameter int TAG_W = REF_W + CRS_W + TAP_W + SUB_W
) (
  input  logic [REF_W-1:0] ref_cnt,
  input  logic [CRS_W-1:0] coarse,
  input  logic [TAP_W-1:0] tap,
  input  logic [SUB_W-1:0] sub,
  input  logic             fine,
  output logic [TAG_W-1:0] mask,
  output logic [TAG_W-1:0] tag
);
  localparam logic [TAG_W-1:0] COARSE_MASK = {{(TAG_W-SUB_W){1'b1}}, {SUB_W{1'b0}}};

  always_comb begin
    mask = fine ? '1 : COARSE_MASK;
    tag  = {ref_cnt, coarse, tap, sub} & mask;
  end
endmodule

// File: rtl/hte_pair.sv
module hte_pair #(
  parameter int NCH   = 4,
  parameter int TAG_W = 25,
  parameter int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             clr_en,
  input  logic [CH_W-1:0]  chan,
  input  logic [TAG_W-1:0] tag_in,
  output logic             pend,
  output logic [TAG_W-1:0] lead_tag
);
  logic [NCH-1:0]   pend_q;
  logic [TAG_W-1:0] lead_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic             sel;
    logic             pend_d;
    logic [TAG_W-1:0] lead_d;

    always_comb begin
      sel    = (chan == CH_W'(g));
      pend_d = pend_q[g];
      lead_d = lead_q[g];
      if (sel && wr_en) begin
        pend_d = 1'b1;
        lead_d = tag_in;
      end else if (sel && clr_en) begin
        pend_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
        lead_q[g] <= '0;
      end else begin
        pend_q[g] <= pend_d;
        lead_q[g] <= lead_d;
      end
    end
  end

  assign pend     = pend_q[chan];
  assign lead_tag = lead_q[chan];

  a_r8_store_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pend_q[$past(chan)]);
endmodule

// File: rtl/hte_oreg.sv
module hte_oreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] q
);
  logic         valid_d;
  logic [W-1:0] q_d;

  always_comb begin
    valid_d = valid;
    q_d     = q;
    if (load) begin
      valid_d = 1'b1;
      q_d     = data;
    end else if (ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else begin
      valid <= valid_d;
      q     <= q_d;
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(q)));
endmodule

// File: rtl/hit_timestamp_encoder.sv
module hit_timestamp_encoder
  import hte_pkg::*;
#(
  parameter int NCH   = 64,
  parameter int REF_W = 12,
  parameter int CRS_W = 6,
  parameter int TAP_W = 5,
  parameter int SUB_W = 2,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TAG_W = REF_W + CRS_W + TAP_W + SUB_W,
  localparam int OUT_W = CH_W + 3 + TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_fine,
  input  logic [TAG_W-1:0] cfg_offset,
  input  logic             hit_valid,
  output logic             hit_ready,
  input  logic [CH_W-1:0]  hit_chan,
  input  logic             hit_lead,
  input  logic [CRS_W-1:0] hit_coarse,
  input  logic [TAP_W-1:0] hit_tap,
  input  logic [SUB_W-1:0] hit_sub,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_word
);
  logic [REF_W-1:0] ref_cnt;
  logic [TAG_W-1:0] mask, tag_m, edge_tag, lead_tag;
  logic             accept, pend;
  logic             emit, store, clr, err;
  logic [1:0]       kind;
  logic [TAG_W-1:0] otag;
  mode_e            mode;

  assign mode      = mode_e'(cfg_mode);
  assign hit_ready = !out_valid || out_ready;
  assign accept    = hit_valid && hit_ready;

  hte_refcnt #(.REF_W(REF_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .cnt(ref_cnt)
  );

  hte_tag #(.REF_W(REF_W), .CRS_W(CRS_W), .TAP_W(TAP_W), .SUB_W(SUB_W), .TAG_W(TAG_W)) u_tag (
    .ref_cnt(ref_cnt), .coarse(hit_coarse), .tap(hit_tap), .sub(hit_sub),
    .fine(cfg_fine), .mask(mask), .tag(tag_m)
  );

  assign edge_tag = tag_m + (cfg_offset & mask);

  always_comb begin
    emit  = 1'b0;
    store = 1'b0;
    clr   = 1'b0;
    err   = 1'b0;
    kind  = KIND_LEAD;
    otag  = edge_tag;
    unique case (mode)
      MODE_LEAD:  emit = hit_lead;
      MODE_TRAIL: begin
        emit = !hit_lead;
        kind = KIND_TRAIL;
      end
      MODE_BOTH: begin
        emit = 1'b1;
        kind = hit_lead ? KIND_LEAD : KIND_TRAIL;
      end
      MODE_TOT: begin
        kind = KIND_TOT;
        if (hit_lead) begin
          store = 1'b1;
        end else begin
          emit = 1'b1;
          clr  = 1'b1;
          if (pend) otag = tag_m - lead_tag;
          else      err  = 1'b1;
        end
      end
      default: emit = 1'b0;
    endcase
    emit  = emit  && accept;
    store = store && accept;
    clr   = clr   && accept;
  end

  hte_pair #(.NCH(NCH), .TAG_W(TAG_W), .CH_W(CH_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .wr_en(store), .clr_en(clr), .chan(hit_chan),
    .tag_in(tag_m), .pend(pend), .lead_tag(lead_tag)
  );

  hte_oreg #(.W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .data({hit_chan, kind, err, otag}),
    .ready(out_ready), .valid(out_valid), .q(out_word)
  );

  a_r3_coarse_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cfg_fine) |-> (out_word[SUB_W-1:0] == '0));
  a_r9_err_only_tot: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word[TAG_W]) |-> (out_word[TAG_W+2:TAG_W+1] == KIND_TOT));
  a_r5_lead_only: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_mode == 2'd0) |-> (out_word[TAG_W+2:TAG_W+1] == KIND_LEAD));
  a_r7_kind_set: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_word[TAG_W+2:TAG_W+1] != 2'b00));
endmodule

// File: tb/hit_timestamp_encoder_tb.sv
`timescale 1ns/1ps
module hit_timestamp_encoder_tb;
  localparam int NCH = 4, REF_W = 4, CRS_W = 6, TAP_W = 5, SUB_W = 2;
  localparam int CH_W = 2, TAG_W = 17, OUT_W = CH_W + 3 + TAG_W;

  logic clk = 1'b0, rst_n;
  logic ref_tick, cfg_fine, hit_valid, hit_ready, hit_lead, out_valid, out_ready;
  logic [1:0] cfg_mode;
  logic [TAG_W-1:0] cfg_offset;
  logic [CH_W-1:0] hit_chan;
  logic [CRS_W-1:0] hit_coarse;
  logic [TAP_W-1:0] hit_tap;
  logic [SUB_W-1:0] hit_sub;
  logic [OUT_W-1:0] out_word;

  hit_timestamp_encoder #(.NCH(NCH), .REF_W(REF_W), .CRS_W(CRS_W), .TAP_W(TAP_W), .SUB_W(SUB_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_mode(cfg_mode), .cfg_fine(cfg_fine),
    .cfg_offset(cfg_offset), .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_chan(hit_chan),
    .hit_lead(hit_lead), .hit_coarse(hit_coarse), .hit_tap(hit_tap), .hit_sub(hit_sub),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [OUT_W-1:0] exp_q[$];
  string req_q[$];
  logic [REF_W-1:0] mref = '0;
  logic m_pend [NCH];
  logic [TAG_W-1:0] m_lead [NCH];
  logic stall_en = 1'b0;

  task automatic chk(input logic ok, input string req, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // out_ready pattern: changes just after each rising edge
  initial begin
    int c = 0;
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      c++;
      out_ready = !(stall_en && (c % 3 != 0));
    end
  end

  // monitor / scoreboard
  initial begin
    logic held = 1'b0;
    logic [OUT_W-1:0] prev = '0;
    forever begin
      @(negedge clk); #0.5;
      if (rst_n) begin
        if (held) chk(out_valid && out_word == prev, "R11 hold", out_word, prev);
        held = out_valid && !out_ready;
        prev = out_word;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) chk(1'b0, "R11 unexpected word", out_word, '0);
          else begin
            logic [OUT_W-1:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk(out_word == e, r, out_word, e);
          end
        end
      end
    end
  end

  task automatic send(input int ch, input logic lead, input int crs, input int tap, input int sub,
                      input logic tick, input string req);
    logic [TAG_W-1:0] fm, raw, edg, t;
    logic [1:0] kind;
    logic err, emit;
    @(negedge clk);
    while (!hit_ready) @(negedge clk);
    hit_valid = 1'b1; hit_chan = CH_W'(ch); hit_lead = lead;
    hit_coarse = CRS_W'(crs); hit_tap = TAP_W'(tap); hit_sub = SUB_W'(sub); ref_tick = tick;
    fm  = cfg_fine ? '1 : ~TAG_W'(3);
    raw = {mref, CRS_W'(crs), TAP_W'(tap), SUB_W'(sub)} & fm;
    edg = (raw + (cfg_offset & fm)) & fm;
    emit = 1'b0; err = 1'b0; kind = 2'b01; t = edg;
    case (cfg_mode)
      2'd0: emit = lead;
      2'd1: begin emit = !lead; kind = 2'b10; end
      2'd2: begin emit = 1'b1; kind = lead ? 2'b01 : 2'b10; end
      default: begin
        kind = 2'b11;
        if (lead) begin m_pend[ch] = 1'b1; m_lead[ch] = raw; end
        else begin
          emit = 1'b1;
          if (m_pend[ch]) t = (raw - m_lead[ch]) & fm; else err = 1'b1;
          m_pend[ch] = 1'b0;
        end
      end
    endcase
    if (emit) begin exp_q.push_back({CH_W'(ch), kind, err, t}); req_q.push_back(req); end
    @(posedge clk);
    if (tick) mref = mref + 1'b1;
    #0.5 hit_valid = 1'b0; ref_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(posedge clk); mref = mref + 1'b1;
      #0.5 ref_tick = 1'b0;
    end
  endtask

  task automatic drain(input string req);
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, req, OUT_W'(exp_q.size()), '0);
  endtask

  initial begin
    #800000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin m_pend[i] = 1'b0; m_lead[i] = '0; end
    rst_n = 1'b0; ref_tick = 0; hit_valid = 0; hit_chan = 0; hit_lead = 0;
    hit_coarse = 0; hit_tap = 0; hit_sub = 0;
    cfg_mode = 2'd2; cfg_fine = 1'b1; cfg_offset = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    chk(!out_valid, "R1 out_valid", OUT_W'(out_valid), '0);
    chk(hit_ready, "R1 hit_ready", OUT_W'(hit_ready), 1);

    // R1/R2/R7 both edges, fine, no offset
    send(0, 1, 5, 17, 2, 0, "R1 R2 first tag ref 0");
    send(1, 0, 63, 31, 3, 1, "R7 trailing kind");
    send(2, 1, 1, 0, 1, 0, "R2 ref count after tick");
    ticks(3);
    send(3, 0, 40, 9, 0, 0, "R2 field placement");
    drain("R7 drained");

    // R4 offset wrap
    cfg_offset = 17'h1FFF3;
    send(0, 1, 20, 4, 1, 0, "R4 offset modulo");
    send(1, 0, 0, 0, 0, 0, "R4 offset small tag");
    drain("R4 drained");

    // R3 coarse resolution
    cfg_fine = 1'b0; cfg_offset = 17'h00107;
    send(2, 1, 7, 3, 3, 0, "R3 sub dropped");
    send(3, 0, 9, 30, 1, 1, "R3 sub dropped trail");
    drain("R3 drained");

    // R5 leading only
    cfg_fine = 1'b1; cfg_offset = '0; cfg_mode = 2'd0;
    send(0, 0, 3, 3, 3, 0, "R5 trailing ignored");
    drain("R5 trailing produces nothing");
    send(0, 1, 3, 3, 3, 0, "R5 leading kept");
    drain("R5 drained");

    // R6 trailing only
    cfg_mode = 2'd1;
    send(1, 1, 8, 8, 2, 0, "R6 leading ignored");
    drain("R6 leading produces nothing");
    send(1, 0, 8, 8, 2, 0, "R6 trailing kept");
    drain("R6 drained");

    // R8/R9/R10 time over threshold
    cfg_mode = 2'd3; cfg_offset = 17'd5;
    send(2, 1, 10, 5, 1, 0, "R8 leading stored");
    drain("R8 leading produces nothing");
    ticks(2);
    send(3, 1, 2, 2, 2, 0, "R10 ch3 leading");
    send(2, 0, 12, 1, 3, 0, "R8 tot difference");
    send(3, 0, 50, 20, 0, 1, "R10 ch3 own pair");
    send(1, 0, 4, 4, 0, 0, "R9 orphan trailing");
    send(2, 0, 4, 4, 0, 0, "R9 second trailing orphan");
    drain("R8 drained");

    // R12 wrap of reference count across a pair
    ticks(16 - int'(mref) - 1);
    send(0, 1, 60, 30, 2, 1, "R12 leading before wrap");
    ticks(2);
    send(0, 0, 3, 1, 1, 0, "R12 tot across wrap");
    drain("R12 drained");
    cfg_mode = 2'd2; cfg_offset = '0;
    send(1, 1, 1, 1, 1, 0, "R12 wrapped ref value");
    drain("R12 edge drained");

    // R11 back-pressure
    stall_en = 1'b1;
    for (int i = 0; i < 8; i++) send(i % NCH, i[0], i * 7, i * 3, i, i[1], "R11 stalled stream");
    drain("R11 drained");
    stall_en = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule